// File: doc/BRIEF.md
# Headset button debounce detector

This block watches one headset-button line and reports on a status pin whether the button is pressed. The raw line is brought into the clock domain through a short flip-flop chain. A debounce counter then accepts a new level only after that level has held steady for a programmable number of timing ticks. The tick input sets the real-time scale. For example, a 1 ms tick with the default terminal count of 50 gives a 50 ms debounce window. The block is meant to stay clocked and enabled while the rest of the chip is powered down, so it can report a button event during standby.

Three configuration bits come from an outside register. The enable bit turns the function on or off. The mode bit chooses between two ways of reporting. In transparent mode the status pin follows the debounced button state. In latched mode the status pin shows a sticky "was pressed" flag. The invert bit reverses the polarity of the status pin. The sticky flag is also driven on a read-back pin for a control port. A pulse on the configuration-write strobe clears the flag; this strobe marks any write to the register that holds the mode bits.

Top module: `hsbtn_detect`

## Requirements
- R1: After reset, with the block disabled and invert at 0, `status_o` is 0 and `sticky_o` is 0.
- R2: A low level on `btn_i` means pressed and a high level means released. With `tick_i` held at 1, a level change on `btn_i` reaches `status_o` after exactly SYNC_STAGES + DB_TICKS rising clock edges. It does not appear one edge earlier.
- R3: A level that holds for fewer than DB_TICKS ticks after synchronisation changes nothing. Each return to the accepted level restarts the count.
- R4: The debounce counter advances only on clock edges where `tick_i` is 1.
- R5: While `en_i` is 0, `status_o` shows "not pressed" (that is, it equals `invert_i`) and the counter is held at zero. After re-enabling, a full DB_TICKS count is needed again.
- R6: In transparent mode (`latched_i` = 0), `status_o` follows the debounced pressed state, both on press and on release.
- R7: A debounced press while enabled sets the sticky flag. In latched mode (`latched_i` = 1), `status_o` shows the sticky flag, so it stays asserted after the button is released.
- R8: A `cfg_wr_i` pulse clears the sticky flag. The flag stays clear while the button is still held, until a new debounced press occurs.
- R9: When a debounced press and a `cfg_wr_i` pulse fall on the same clock edge, the flag ends up set.
- R10: With `invert_i` = 0, "pressed" appears on `status_o` as 1. With `invert_i` = 1, it appears as 0.
- R11: `sticky_o` shows the sticky flag in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| tick_i | input | 1 | Debounce timing tick enable |
| btn_i | input | 1 | Raw button level (low = pressed) |
| en_i | input | 1 | Function enable |
| latched_i | input | 1 | 1 = latched reporting, 0 = transparent |
| invert_i | input | 1 | Status output polarity invert |
| cfg_wr_i | input | 1 | Strobe for a write to the mode register; clears the sticky flag |
| status_o | output | 1 | Reported button state after mode and polarity |
| sticky_o | output | 1 | Sticky flag read-back |

## Verification
The debounced press that sets the sticky flag can land on the same clock edge as a mode-register write that clears it. The bench provokes this by counting SYNC_STAGES + DB_TICKS edges from a clean press. It raises `cfg_wr_i` in the cycle before the edge on which the press is accepted. The outcome is judged on `sticky_o` and on the latched `status_o`: both must show the flag set. A second write made one cycle later must then clear the flag while the button is still held.

// File: rtl/hsbtn_pkg.sv
package hsbtn_pkg;

   // Configuration bits as seen by the detector.
   typedef struct packed {
      logic en;
      logic latched;
      logic invert;
   } hsbtn_cfg_t;

   // Reported level before polarity is applied.
   function automatic logic hsbtn_shown(input hsbtn_cfg_t cfg,
                                        input logic pressed,
                                        input logic sticky);
      logic sel;
      sel = cfg.latched ? sticky : pressed;
      return cfg.en & sel;
   endfunction

endpackage

// File: rtl/hsbtn_sync.sv
module hsbtn_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("hsbtn_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/hsbtn_debounce.sv
module hsbtn_debounce #(
   parameter int unsigned DB_TICKS = 50
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic tick_i,
   input  logic lvl_i,
   output logic stable_o,
   output logic press_evt_o
);

   localparam int unsigned CNT_W = (DB_TICKS > 1) ? $clog2(DB_TICKS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DB_TICKS - 1);

   if (DB_TICKS < 1) begin : g_bad_ticks
      $error("hsbtn_debounce: DB_TICKS must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             stable_q;
   logic             differ;
   logic             expire;

   assign differ = lvl_i != stable_q;
   assign expire = run_i & differ & tick_i & (cnt_q == LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q    <= '0;
         stable_q <= 1'b0;
      end else if (!run_i) begin
         cnt_q    <= '0;
         stable_q <= 1'b0;
      end else if (!differ) begin
         cnt_q    <= '0;
      end else if (tick_i) begin
         if (cnt_q == LAST) begin
            stable_q <= lvl_i;
            cnt_q    <= '0;
         end else begin
            cnt_q    <= cnt_q + 1'b1;
         end
      end
   end

   assign stable_o    = stable_q;
   assign press_evt_o = expire & lvl_i;

endmodule

// File: rtl/hsbtn_report.sv
module hsbtn_report
   import hsbtn_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  hsbtn_cfg_t cfg_i,
   input  logic       clr_i,
   input  logic       press_evt_i,
   input  logic       pressed_i,
   output logic       status_o,
   output logic       sticky_o
);

   logic sticky_q;

   // A press accepted on the same edge as a clear wins.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          sticky_q <= 1'b0;
      else if (press_evt_i) sticky_q <= 1'b1;
      else if (clr_i)       sticky_q <= 1'b0;
   end

   assign status_o = hsbtn_shown(cfg_i, pressed_i, sticky_q) ^ cfg_i.invert;
   assign sticky_o = sticky_q;

endmodule

// File: rtl/hsbtn_detect.sv
module hsbtn_detect
   import hsbtn_pkg::*;
#(
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned DB_TICKS       = 50,
   parameter bit          BTN_ACTIVE_LOW = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic btn_i,
   input  logic en_i,
   input  logic latched_i,
   input  logic invert_i,
   input  logic cfg_wr_i,
   output logic status_o,
   output logic sticky_o
);

   localparam logic IDLE_LVL = BTN_ACTIVE_LOW ? 1'b1 : 1'b0;

   logic       sync_q;
   logic       pressed_sync;
   logic       deb_pressed;
   logic       press_evt;
   hsbtn_cfg_t cfg;

   assign cfg = '{en: en_i, latched: latched_i, invert: invert_i};

   hsbtn_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_LVL)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (btn_i),
      .q_o   (sync_q)
   );

   if (BTN_ACTIVE_LOW) begin : g_act_low
      assign pressed_sync = ~sync_q;
   end else begin : g_act_high
      assign pressed_sync = sync_q;
   end

   hsbtn_debounce #(.DB_TICKS(DB_TICKS)) u_deb (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (en_i),
      .tick_i     (tick_i),
      .lvl_i      (pressed_sync),
      .stable_o   (deb_pressed),
      .press_evt_o(press_evt)
   );

   hsbtn_report u_rep (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_i      (cfg),
      .clr_i      (cfg_wr_i),
      .press_evt_i(press_evt),
      .pressed_i  (deb_pressed),
      .status_o   (status_o),
      .sticky_o   (sticky_o)
   );

endmodule

// File: rtl/hsbtn_detect_chk.sv
module hsbtn_detect_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic en_i,
   input logic latched_i,
   input logic invert_i,
   input logic cfg_wr_i,
   input logic status_o,
   input logic sticky_o,
   input logic deb_pressed,
   input logic pressed_sync,
   input logic press_evt
);

   // R5: disabled means "not pressed" after polarity
   p_idle_when_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |-> status_o == invert_i);

   // R3: accepted level only moves toward a differing synchronised level
   p_deb_moves_toward_input_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && $past(en_i) && deb_pressed != $past(deb_pressed))
         |-> $past(pressed_sync) != $past(deb_pressed));

   // R7: flag rises only together with a new debounced press
   p_sticky_from_press_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sticky_o) |-> deb_pressed && !$past(deb_pressed));

   // R8: a write with no press clears the flag
   p_clear_on_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_wr_i && !press_evt) |=> !sticky_o);

   // R9: a press always leaves the flag set
   p_press_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      press_evt |=> sticky_o);

   // R10: transparent pressed level follows polarity bit
   p_polarity_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !latched_i && deb_pressed) |-> status_o == !invert_i);

endmodule

bind hsbtn_detect hsbtn_detect_chk u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .en_i        (en_i),
   .latched_i   (latched_i),
   .invert_i    (invert_i),
   .cfg_wr_i    (cfg_wr_i),
   .status_o    (status_o),
   .sticky_o    (sticky_o),
   .deb_pressed (deb_pressed),
   .pressed_sync(pressed_sync),
   .press_evt   (press_evt)
);

// File: tb/hsbtn_detect_tb_top.sv
module hsbtn_detect_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int SYNC = 2;
   localparam int DB   = 4;
   localparam int LAT  = SYNC + DB;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b1;
   logic btn = 1'b1;
   logic en = 1'b0;
   logic lat = 1'b0;
   logic inv = 1'b0;
   logic wr = 1'b0;
   logic status;
   logic sticky;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hsbtn_detect #(.SYNC_STAGES(SYNC), .DB_TICKS(DB), .BTN_ACTIVE_LOW(1'b1)) dut_i (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .tick_i   (tick),
      .btn_i    (btn),
      .en_i     (en),
      .latched_i(lat),
      .invert_i (inv),
      .cfg_wr_i (wr),
      .status_o (status),
      .sticky_o (sticky)
   );

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string rq, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b", rq, act, exp);
      end
   endtask

   function automatic logic expo(input logic e, input logic l, input logic i,
                                 input logic prs, input logic stk);
      return (e & (l ? stk : prs)) ^ i;
   endfunction

   task automatic clear_flag();
      wr = 1'b1;
      step(1);
      wr = 1'b0;
   endtask

   initial begin
      @(negedge clk);
      step(2);
      // R1 reset state
      chk("R1 status", status, 1'b0);
      chk("R1 sticky", sticky, 1'b0);
      rst_n = 1'b1;
      step(2);
      chk("R1 status after release", status, 1'b0);

      // Sweep of all configurations: R2 R5 R6 R7 R10 R11
      for (int c = 0; c < 8; c++) begin
         en  = c[0];
         lat = c[1];
         inv = c[2];
         clear_flag();
         chk("R10 idle", status, expo(en, lat, inv, 1'b0, 1'b0));
         btn = 1'b0;
         step(LAT - 1);
         chk("R2 not yet", status, expo(en, lat, inv, 1'b0, 1'b0));
         step(1);
         chk("R6 R7 pressed", status, expo(en, lat, inv, en, en));
         chk("R11 sticky", sticky, en);
         btn = 1'b1;
         step(LAT);
         chk("R6 R7 released", status, expo(en, lat, inv, 1'b0, en));
         chk("R11 sticky kept", sticky, en);
      end

      // R3 glitch rejection and restart
      en = 1'b1; lat = 1'b0; inv = 1'b0;
      clear_flag();
      btn = 1'b0; step(DB - 1);
      btn = 1'b1; step(1);
      btn = 1'b0; step(DB - 1);
      btn = 1'b1; step(LAT + 4);
      chk("R3 bounce rejected", status, 1'b0);
      chk("R3 no sticky", sticky, 1'b0);

      // R4 tick gating
      tick = 1'b0;
      btn = 1'b0;
      step(LAT + 10);
      chk("R4 no tick no change", status, 1'b0);
      tick = 1'b1;
      step(DB - 1);
      chk("R4 one tick short", status, 1'b0);
      step(1);
      chk("R4 after ticks", status, 1'b1);
      btn = 1'b1;
      step(LAT);
      chk("R4 release", status, 1'b0);

      // R5 disable mid count, restart from zero
      btn = 1'b0;
      step(LAT - 1);
      en = 1'b0;
      step(1);
      chk("R5 disabled idle", status, 1'b0);
      en = 1'b1;
      step(DB - 1);
      chk("R5 counter restarted", status, 1'b0);
      step(1);
      chk("R5 accepted after full count", status, 1'b1);
      btn = 1'b1;
      step(LAT);

      // R8 clear while held
      lat = 1'b1;
      clear_flag();
      btn = 1'b0;
      step(LAT);
      chk("R8 set before clear", status, 1'b1);
      clear_flag();
      chk("R8 cleared", sticky, 1'b0);
      step(10);
      chk("R8 stays clear while held", status, 1'b0);
      btn = 1'b1;
      step(LAT);
      btn = 1'b0;
      step(LAT);
      chk("R8 new press sets", sticky, 1'b1);
      btn = 1'b1;
      step(LAT);

      // R9 press and write on the same edge
      clear_flag();
      btn = 1'b0;
      step(LAT - 1);
      wr = 1'b1;
      step(1);
      wr = 1'b0;
      chk("R9 press wins sticky", sticky, 1'b1);
      chk("R9 press wins status", status, 1'b1);
      clear_flag();
      chk("R9 later write clears", sticky, 1'b0);
      btn = 1'b1;
      step(LAT);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule